// File: doc/BRIEF.md
# DMA line-splitting request sequencer

This block takes DMA transfers (start byte address, byte length, read or write) from an upstream agent and cuts each one into memory messages that never cross a cache-line boundary. At most one message per transfer is in flight. Each downstream response, whether read data or a write acknowledgement, makes the block issue that transfer's next chunk. A small table holds several transfers at once. Each entry is tracked under the line address of the transfer's first byte, and every message and response carries that line address as its tag.

Read bytes returned by memory are gathered into a per-entry byte buffer. Write bytes come with the request and are placed into each outgoing line block at the right offset. When the last chunk of a transfer has been answered, the block frees the entry and pulses a completion carrying the start address, the direction and the buffer contents. Request acceptance is decided in the same cycle, and a status code reports the outcome.

Top module: `dma_split_seq`

## Requirements
- R1: After reset, `msg_valid` and `done_valid` are low and the table is empty.
- R2: A request is refused with status 3 (reject) if its length is zero, if its length exceeds MAX_LEN bytes, or if `rsp_valid` is high in the same cycle. A refused request sends no message and changes no state.
- R3: If the table already holds MAX_OUT transfers, a request gets status 1 (full) and sends no message.
- R4: If a live entry already has the request's start line address (the address with its low log2(LINE_BYTES) bits cleared), the request gets status 2 (aliased) and sends no message.
- R5: An accepted request gets status 0 (issued) in the same cycle. Its first message appears one cycle later. That message has `msg_paddr` equal to the start address and `msg_key` equal to the start line address. Its length is the whole request length if the offset within the line plus the length is at most LINE_BYTES, and LINE_BYTES minus the offset otherwise.
- R6: `msg_store` is 1 for a write transfer and 0 for a read transfer.
- R7: Each response for a transfer that is not yet finished produces exactly one new message, one cycle later. Its address is the start address plus the bytes already covered, which is line-aligned. Its length is the smaller of LINE_BYTES and the bytes still remaining.
- R8: For a write message, byte j of `msg_data` (bits 8j+7:8j) holds write byte k+j-o for every j in the chunk window [o, o+len), where o is the chunk's line offset and k is the bytes already covered. All other bytes are zero, and read messages carry all-zero data.
- R9: For a read, each data response copies issued-minus-completed bytes into the buffer at position completed. The bytes come from the returned line starting at byte 0, except for the first chunk, where they start at the start address's line offset. Buffer bytes past the length stay zero.
- R10: The cycle after the response that covers the last byte, `done_valid` pulses for one cycle with the start address, the direction and the buffer: gathered data for a read, the stored write bytes for a write. The entry is then free for a new request on that line.
- R11: The count of outstanding transfers always equals the number of live table entries and never exceeds MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New transfer offered this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| req_store | input | 1 | 1 = write, 0 = read |
| req_wdata | input | MAX_LEN*8 | Write bytes, byte i at bits 8i+7:8i |
| req_status | output | 2 | 0 issued, 1 full, 2 aliased, 3 reject |
| rsp_valid | input | 1 | Downstream response this cycle |
| rsp_key | input | ADDR_W | Tag echoed from the message (start line address) |
| rsp_is_data | input | 1 | 1 = read data response, 0 = write acknowledgement |
| rsp_data | input | LINE_BYTES*8 | Returned line block |
| msg_valid | output | 1 | Message pulse toward memory |
| msg_paddr | output | ADDR_W | Byte address of the chunk |
| msg_key | output | ADDR_W | Start line address of the owning transfer |
| msg_store | output | 1 | Store (1) or load (0) |
| msg_len | output | CLEN_W | Chunk length in bytes |
| msg_data | output | LINE_BYTES*8 | Line block with write bytes at the chunk offset |
| done_valid | output | 1 | Transfer completion pulse |
| done_addr | output | ADDR_W | Start address of the finished transfer |
| done_store | output | 1 | Direction of the finished transfer |
| done_rdata | output | MAX_LEN*8 | Buffer contents of the finished transfer |

## Verification
The status code is combinational, so the bench reads it a short delay after driving the request, inside the same cycle. Every message and every completion passes through exactly one register after the cycle in which its request or response is presented. The bench drives stimulus on a falling edge, lets one rising edge pass, and samples at the next falling edge. At that point it checks both that the expected pulse is present and that no unexpected pulse appears, for example after a refused request or before the last chunk of a transfer has been answered.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_FULL   = 2'd1,
    ST_ALIAS  = 2'd2,
    ST_REJECT = 2'd3
  } req_status_e;
endpackage

// File: rtl/dma_split_match.sv
module dma_split_match #(
  parameter int N  = 4,
  parameter int W  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0][W-1:0] keys,
  input  logic [W-1:0]        probe,
  output logic                hit,
  output logic [IW-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i] && keys[i] == probe) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_split_alloc.sv
module dma_split_alloc #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  valid,
  output logic          any_free,
  output logic [IW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_split_window.sv
module dma_split_window #(
  parameter int IN_B  = 64,
  parameter int OUT_B = 128,
  parameter int SB_W  = 6,
  parameter int DB_W  = 8,
  parameter int C_W   = 8
) (
  input  logic [IN_B*8-1:0]  src,
  input  logic [OUT_B*8-1:0] keep,
  input  logic [SB_W-1:0]    src_base,
  input  logic [DB_W-1:0]    dst_base,
  input  logic [C_W-1:0]     count,
  output logic [OUT_B*8-1:0] dst
);
  for (genvar j = 0; j < OUT_B; j++) begin : g_byte
    int   rel;
    int   sp;
    logic in_win;
    assign rel    = j - int'(dst_base);
    assign sp     = rel + int'(src_base);
    assign in_win = (rel >= 0) && (rel < int'(count)) && (sp < IN_B);
    assign dst[j*8 +: 8] = in_win ? src[sp*8 +: 8] : keep[j*8 +: 8];
  end
endmodule

// File: rtl/dma_split_seq.sv
module dma_split_seq
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 4,
  parameter int MAX_LEN    = 128,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int CLEN_W = $clog2(LINE_BYTES + 1),
  localparam int IDX_W  = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    req_store,
  input  logic [MAX_LEN*8-1:0]    req_wdata,
  output logic [1:0]              req_status,
  input  logic                    rsp_valid,
  input  logic [ADDR_W-1:0]       rsp_key,
  input  logic                    rsp_is_data,
  input  logic [LINE_BYTES*8-1:0] rsp_data,
  output logic                    msg_valid,
  output logic [ADDR_W-1:0]       msg_paddr,
  output logic [ADDR_W-1:0]       msg_key,
  output logic                    msg_store,
  output logic [CLEN_W-1:0]       msg_len,
  output logic [LINE_BYTES*8-1:0] msg_data,
  output logic                    done_valid,
  output logic [ADDR_W-1:0]       done_addr,
  output logic                    done_store,
  output logic [MAX_LEN*8-1:0]    done_rdata
);
  // arithmetic helpers
  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [CLEN_W-1:0] chunk_len(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0]  rem);
    int room;
    room = LINE_BYTES - int'(a[OFF_W-1:0]);
    return (int'(rem) < room) ? CLEN_W'(rem) : CLEN_W'(room);
  endfunction

  // request table
  logic [MAX_OUT-1:0]             ent_valid;
  logic [MAX_OUT-1:0]             ent_store;
  logic [ADDR_W-1:0]              ent_start  [MAX_OUT];
  logic [LEN_W-1:0]               ent_len    [MAX_OUT];
  logic [LEN_W-1:0]               ent_issued [MAX_OUT];
  logic [LEN_W-1:0]               ent_done   [MAX_OUT];
  logic [MAX_LEN*8-1:0]           ent_buf    [MAX_OUT];
  logic [MAX_OUT-1:0][ADDR_W-1:0] ent_key;
  logic [CNT_W-1:0]               out_cnt;
  logic                           msg_first;

  for (genvar g = 0; g < MAX_OUT; g++) begin : g_key
    assign ent_key[g] = line_of(ent_start[g]);
  end

  // response side
  logic             rsp_hit;
  logic [IDX_W-1:0] rsp_idx;
  dma_split_match #(.N(MAX_OUT), .W(ADDR_W)) u_rsp_match (
    .valid(ent_valid), .keys(ent_key), .probe(rsp_key), .hit(rsp_hit), .idx(rsp_idx)
  );

  logic [ADDR_W-1:0]    e_start;
  logic [LEN_W-1:0]     e_len, e_issued, e_done, rd_count;
  logic                 e_store;
  logic [OFF_W-1:0]     rd_srcoff;
  logic [MAX_LEN*8-1:0] gathered;
  logic                 rsp_take, rsp_finish, rsp_next;
  logic [ADDR_W-1:0]    next_addr;
  logic [CLEN_W-1:0]    next_clen;

  assign e_start    = ent_start[rsp_idx];
  assign e_len      = ent_len[rsp_idx];
  assign e_issued   = ent_issued[rsp_idx];
  assign e_done     = ent_done[rsp_idx];
  assign e_store    = ent_store[rsp_idx];
  assign rd_srcoff  = (e_done == '0) ? e_start[OFF_W-1:0] : '0;
  assign rd_count   = (rsp_is_data && !e_store) ? (e_issued - e_done) : '0;
  assign rsp_take   = rsp_valid && rsp_hit;
  assign rsp_finish = rsp_take && (e_issued == e_len);
  assign rsp_next   = rsp_take && (e_issued != e_len);
  assign next_addr  = e_start + ADDR_W'(e_issued);
  assign next_clen  = chunk_len(next_addr, e_len - e_issued);

  dma_split_window #(
    .IN_B(LINE_BYTES), .OUT_B(MAX_LEN), .SB_W(OFF_W), .DB_W(LEN_W), .C_W(LEN_W)
  ) u_gather (
    .src(rsp_data), .keep(ent_buf[rsp_idx]), .src_base(rd_srcoff),
    .dst_base(e_done), .count(rd_count), .dst(gathered)
  );

  // request side
  logic             alias_hit, any_free, len_bad, req_accept;
  logic [IDX_W-1:0] alias_idx, free_idx;
  logic [CLEN_W-1:0] first_clen;
  req_status_e      status;

  dma_split_match #(.N(MAX_OUT), .W(ADDR_W)) u_alias_match (
    .valid(ent_valid), .keys(ent_key), .probe(line_of(req_addr)),
    .hit(alias_hit), .idx(alias_idx)
  );
  dma_split_alloc #(.N(MAX_OUT)) u_alloc (
    .valid(ent_valid), .any_free(any_free), .idx(free_idx)
  );

  assign len_bad    = (req_len == '0) || (int'(req_len) > MAX_LEN);
  assign first_clen = chunk_len(req_addr, req_len);

  always_comb begin
    if (len_bad || rsp_valid)         status = ST_REJECT;
    else if (out_cnt == CNT_W'(MAX_OUT) || !any_free) status = ST_FULL;
    else if (alias_hit)               status = ST_ALIAS;
    else                              status = ST_ISSUED;
  end
  assign req_status = status;
  assign req_accept = req_valid && (status == ST_ISSUED);

  // message source selection
  logic                 iss_fire, iss_store;
  logic [ADDR_W-1:0]    iss_addr, iss_key;
  logic [CLEN_W-1:0]    iss_clen;
  logic [MAX_LEN*8-1:0] iss_buf;
  logic [LEN_W-1:0]     iss_base;
  logic [LINE_BYTES*8-1:0] iss_data;

  assign iss_fire  = rsp_next || req_accept;
  assign iss_addr  = rsp_next ? next_addr : req_addr;
  assign iss_key   = rsp_next ? line_of(e_start) : line_of(req_addr);
  assign iss_clen  = rsp_next ? next_clen : first_clen;
  assign iss_store = rsp_next ? e_store : req_store;
  assign iss_buf   = rsp_next ? ent_buf[rsp_idx] : req_wdata;
  assign iss_base  = rsp_next ? e_issued : '0;

  dma_split_window #(
    .IN_B(MAX_LEN), .OUT_B(LINE_BYTES), .SB_W(LEN_W), .DB_W(OFF_W), .C_W(CLEN_W)
  ) u_pack (
    .src(iss_buf), .keep('0), .src_base(iss_base), .dst_base(iss_addr[OFF_W-1:0]),
    .count(iss_store ? iss_clen : '0), .dst(iss_data)
  );

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      out_cnt    <= '0;
      msg_valid  <= 1'b0;
      done_valid <= 1'b0;
      msg_first  <= 1'b0;
    end else begin
      msg_valid  <= iss_fire;
      done_valid <= rsp_finish;
      msg_first  <= req_accept;
      if (req_accept) begin
        ent_valid[free_idx] <= 1'b1;
        out_cnt             <= out_cnt + 1'b1;
      end
      if (rsp_finish) begin
        ent_valid[rsp_idx] <= 1'b0;
        out_cnt            <= out_cnt - 1'b1;
      end
    end
  end

  // payload state
  always_ff @(posedge clk) begin
    if (iss_fire) begin
      msg_paddr <= iss_addr;
      msg_key   <= iss_key;
      msg_store <= iss_store;
      msg_len   <= iss_clen;
      msg_data  <= iss_data;
    end
    if (req_accept) begin
      ent_start[free_idx]  <= req_addr;
      ent_len[free_idx]    <= req_len;
      ent_store[free_idx]  <= req_store;
      ent_issued[free_idx] <= LEN_W'(first_clen);
      ent_done[free_idx]   <= '0;
      ent_buf[free_idx]    <= req_store ? req_wdata : '0;
    end
    if (rsp_take) begin
      ent_done[rsp_idx] <= e_issued;
      ent_buf[rsp_idx]  <= gathered;
      if (rsp_next) ent_issued[rsp_idx] <= e_issued + LEN_W'(next_clen);
    end
    if (rsp_finish) begin
      done_addr  <= e_start;
      done_store <= e_store;
      done_rdata <= gathered;
    end
  end

  // assertions
  assert_occupancy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CNT_W'($countones(ent_valid))) && (int'(out_cnt) <= MAX_OUT));

  assert_msg_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_len != '0) &&
                  (int'(msg_paddr[OFF_W-1:0]) + int'(msg_len) <= LINE_BYTES));

  assert_later_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_first) |-> (msg_paddr[OFF_W-1:0] == '0));

  assert_refused_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid && req_status != ST_ISSUED) |=> !msg_valid);

  assert_msg_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(rsp_valid || req_valid));

  assert_done_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(rsp_valid));
endmodule

// File: tb/dma_split_seq_test.sv
`timescale 1ns/1ps
module dma_split_seq_test;
  localparam int LB = 64;
  localparam int MB = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [7:0]    req_len = '0;
  logic          req_store = 1'b0;
  logic [MB*8-1:0] req_wdata = '0;
  logic [1:0]    req_status;
  logic          rsp_valid = 1'b0;
  logic [31:0]   rsp_key = '0;
  logic          rsp_is_data = 1'b0;
  logic [LB*8-1:0] rsp_data = '0;
  logic          msg_valid;
  logic [31:0]   msg_paddr, msg_key;
  logic          msg_store;
  logic [6:0]    msg_len;
  logic [LB*8-1:0] msg_data;
  logic          done_valid;
  logic [31:0]   done_addr;
  logic          done_store;
  logic [MB*8-1:0] done_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  dma_split_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_store(req_store), .req_wdata(req_wdata),
    .req_status(req_status), .rsp_valid(rsp_valid), .rsp_key(rsp_key),
    .rsp_is_data(rsp_is_data), .rsp_data(rsp_data), .msg_valid(msg_valid),
    .msg_paddr(msg_paddr), .msg_key(msg_key), .msg_store(msg_store),
    .msg_len(msg_len), .msg_data(msg_data), .done_valid(done_valid),
    .done_addr(done_addr), .done_store(done_store), .done_rdata(done_rdata)
  );

  always #2.5 clk = ~clk;

  // stimulus table: start address, length, write flag, expected chunk count
  localparam logic [31:0] V_ADDR [8] = '{32'h1000, 32'h2030, 32'h3038, 32'h4010,
                                         32'h5000, 32'h6001, 32'h703F, 32'h8000};
  localparam int V_LEN [8] = '{16, 16, 16, 128, 128, 1, 66, 64};
  localparam bit V_ST  [8] = '{0, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_NCH [8] = '{1, 1, 2, 3, 2, 1, 3, 1};

  task automatic chk(input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [31:0] a);
    logic [31:0] m;
    m = (a * 32'd13) ^ (a >> 8);
    return m[7:0];
  endfunction

  function automatic logic [LB*8-1:0] line_blk(input logic [31:0] line);
    logic [LB*8-1:0] d;
    for (int j = 0; j < LB; j++) d[j*8 +: 8] = rdb(line + 32'(j));
    return d;
  endfunction

  function automatic logic [MB*8-1:0] wpat(input int seed);
    logic [MB*8-1:0] w;
    for (int i = 0; i < MB; i++) w[i*8 +: 8] = 8'(i * 7 + seed);
    return w;
  endfunction

  function automatic logic [MB*8-1:0] rd_expect(input logic [31:0] a, input int l);
    logic [MB*8-1:0] e;
    e = '0;
    for (int i = 0; i < l; i++) e[i*8 +: 8] = rdb(a + 32'(i));
    return e;
  endfunction

  task automatic send_req(input logic [31:0] a, input int l, input bit s,
                          input logic [MB*8-1:0] w, output logic [1:0] st);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 8'(l); req_store = s; req_wdata = w;
    #1 st = req_status;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic [31:0] key, input logic [31:0] line, input bit isdata);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_key = key; rsp_is_data = isdata; rsp_data = line_blk(line);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_req(input logic [31:0] a, input int l, input bit s,
                         input int nch_exp, input int seed);
    logic [MB*8-1:0] w;
    logic [LB*8-1:0] exp;
    logic [1:0] st;
    int covered, nch, cur, off, clen;
    w = wpat(seed);
    send_req(a, l, s, w, st);
    chk("R5 status issued", st, 0);
    covered = 0;
    nch = 0;
    while (covered < l) begin
      cur = int'(a) + covered;
      off = cur % LB;
      if (covered == 0) clen = (off + l <= LB) ? l : LB - off;
      else              clen = (l - covered < LB) ? l - covered : LB;
      chk("R5/R7 msg_valid", msg_valid, 1);
      chk("R5/R7 msg_paddr", msg_paddr, cur);
      chk("R5 msg_key", msg_key, a & ~32'(LB - 1));
      chk("R5/R7 msg_len", msg_len, clen);
      chk("R6 msg_store", msg_store, s);
      exp = '0;
      if (s)
        for (int j = 0; j < LB; j++)
          if (j >= off && j < off + clen) exp[j*8 +: 8] = w[(covered + j - off)*8 +: 8];
      chk("R8 msg_data", msg_data, exp);
      if (covered > 0) chk("R10 no early done", done_valid, 0);
      send_rsp(a & ~32'(LB - 1), 32'(cur) & ~32'(LB - 1), !s);
      covered += clen;
      nch++;
    end
    chk("R7 chunk count", nch, nch_exp);
    chk("R7 no extra msg", msg_valid, 0);
    chk("R10 done_valid", done_valid, 1);
    chk("R10 done_addr", done_addr, a);
    chk("R10 done_store", done_store, s);
    chk("R9/R10 done data", done_rdata, s ? w : rd_expect(a, l));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset msg_valid", msg_valid, 0);
    chk("R1 reset done_valid", done_valid, 0);

    for (int v = 0; v < 8; v++) run_req(V_ADDR[v], V_LEN[v], V_ST[v], V_NCH[v], v * 11);

    // alias, collision and full
    send_req(32'h9000, 128, 1'b0, '0, st);
    chk("R5 A issued", st, 0);
    chk("R5 A first msg", msg_len, 64);
    send_req(32'h9020, 4, 1'b0, '0, st);
    chk("R4 aliased status", st, 2);
    chk("R4 no msg after alias", msg_valid, 0);

    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hA000; req_len = 8'd4; req_store = 1'b0;
    rsp_valid = 1'b1; rsp_key = 32'h9000; rsp_is_data = 1'b1; rsp_data = line_blk(32'h9000);
    #1 chk("R2 collision reject", req_status, 3);
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    chk("R7 next msg after rsp", msg_valid, 1);
    chk("R7 next msg addr", msg_paddr, 32'h9040);
    chk("R7 next msg len", msg_len, 64);

    send_req(32'hB000, 16, 1'b0, '0, st); chk("R5 B issued", st, 0);
    send_req(32'hC000, 16, 1'b0, '0, st); chk("R5 C issued", st, 0);
    send_req(32'hD000, 16, 1'b0, '0, st); chk("R5 D issued", st, 0);
    send_req(32'hE000, 16, 1'b0, '0, st);
    chk("R3 full status", st, 1);
    chk("R3 no msg when full", msg_valid, 0);

    send_rsp(32'h9000, 32'h9040, 1'b1);
    chk("R10 A done", done_valid, 1);
    chk("R9 A gathered", done_rdata, rd_expect(32'h9000, 128));
    send_rsp(32'hB000, 32'hB000, 1'b1);
    chk("R9 B gathered", done_rdata, rd_expect(32'hB000, 16));
    send_rsp(32'hC000, 32'hC000, 1'b1);
    chk("R10 C done", done_addr, 32'hC000);
    send_rsp(32'hD000, 32'hD000, 1'b1);
    chk("R10 D done", done_valid, 1);

    // line freed and refused requests left nothing behind
    run_req(32'h9010, 8, 1'b0, 1, 3);
    run_req(32'hE000, 16, 1'b1, 1, 5);

    send_req(32'hF000, 0, 1'b0, '0, st);
    chk("R2 zero length reject", st, 3);
    chk("R2 no msg after reject", msg_valid, 0);
    send_req(32'hF000, 129, 1'b0, '0, st);
    chk("R2 too long reject", st, 3);
    chk("R2 no msg after long", msg_valid, 0);
    run_req(32'hA000, 4, 1'b0, 1, 9);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule